// File: doc/BRIEF.md
# Indexed Configuration Window

This block holds a 256-byte configuration register file that the host reaches through a two-byte I/O window. A byte written to the lower window address selects which register is current. A byte written to the upper window address is stored in the current register, but only when that register is open for writing. Two registers accept exactly one value each, so every other value written to them is dropped. A read at either window address returns the byte in the current register.

The window stays closed until the host sets it open through a separate host configuration write path. While the window is closed, the block does not respond to window accesses. Each access that is answered is reported one cycle later on a registered hit output, and read data follows with the same one-cycle delay. The devices that these registers configure sit outside this block.

Top module: `cfg_window`

## Requirements
- R1: A write at I/O address 0x3F0, while the window is enabled, stores the 8-bit write data as the current index. Later data reads and writes use that index.
- R2: A read at 0x3F0 or 0x3F1, while the window is enabled, returns on io_rdata the byte stored at the current index, in the cycle after the read.
- R3: A write at 0x3F1 changes nothing when the current index is in one of these ranges: 0x00–0xDF, 0xE4–0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: At index 0xE7 a data write takes effect only if the value is 0xFE. At index 0xE8 it takes effect only if the value is 0xBE. Any other value leaves the register unchanged.
- R5: At indices 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC, a data write stores the written byte.
- R6: Reset sets these registers: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. All other registers and the index reset to 0x00, and the window resets to disabled.
- R7: A host configuration write to offset 0x85 sets the window enable to bit 1 of the written byte, starting with the next cycle. A host write to any other offset leaves the enable unchanged.
- R8: While the window is disabled, an access at 0x3F0 or 0x3F1 gives io_hit=0 and io_rdata=0xFF, and it changes neither the index nor any register.
- R9: An access at any address outside 0x3F0–0x3F1 gives io_hit=0 and io_rdata=0xFF, and it changes no state.
- R10: io_hit is 1 in the cycle after an access (a read or a write) that fell in the enabled window, and 0 in every other cycle. Whenever a cycle does not return read data, io_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host configuration write strobe |
| host_off | input | 8 | Host configuration byte offset |
| host_wdata | input | 8 | Host configuration write byte |
| io_addr | input | 16 | I/O address of the access |
| io_wdata | input | 8 | I/O write byte |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Registered read byte, 0xFF when no read returns data |
| io_hit | output | 1 | Registered flag: the previous access was answered |

## Verification
Every window result comes one clock after its access: io_hit and io_rdata are registered on the edge that samples the strobes. An index or data write is therefore visible to a read presented on the very next cycle. A host write to the enable offset governs accesses from the following cycle onward. The bench drives each access on a falling edge and records the expected hit and byte for that access in a queue. A monitor then takes one entry just after each rising edge that follows, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 1 << BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // Power-on content of one configuration register.
    function automatic byte_t reg_init(input byte_t idx);
        byte_t v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = 8'hFE;
            8'hE8:   v = 8'hBE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    // Registers that take any written byte.
    function automatic logic reg_free(input byte_t idx);
        logic ok;
        case (idx)
            8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
            8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
            8'hF4, 8'hF6, 8'hF8, 8'hFC: ok = 1'b1;
            default:                    ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Registers that take a single fixed byte: returns {pinned, value}.
    function automatic logic [BYTE_W:0] reg_pin(input byte_t idx);
        logic [BYTE_W:0] r;
        case (idx)
            8'hE7:   r = {1'b1, 8'hFE};
            8'hE8:   r = {1'b1, 8'hBE};
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              open,
    output logic              acc,
    output logic              wr_sel,
    output logic              wr_val,
    output logic              rd_any
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] VAL_ADDR = ADDR_W'(BASE_ADDR + 16'd1);

    logic at_sel;
    logic at_val;

    always_comb begin
        at_sel = (addr == SEL_ADDR);
        at_val = (addr == VAL_ADDR);
        acc    = open && (at_sel || at_val) && (wr || rd);
        wr_sel = open && at_sel && wr;
        wr_val = open && at_val && wr;
        rd_any = open && (at_sel || at_val) && rd;
    end

endmodule

// File: rtl/cfgwin_filter.sv
module cfgwin_filter
    import cfgwin_pkg::*;
(
    input  byte_t idx,
    input  byte_t val,
    output logic  accept
);
    logic [BYTE_W:0] pin;

    always_comb begin
        pin = reg_pin(idx);
        if (pin[BYTE_W]) begin
            accept = (val == pin[BYTE_W-1:0]);
        end else begin
            accept = reg_free(idx);
        end
    end

endmodule

// File: rtl/cfgwin_store.sv
module cfgwin_store
    import cfgwin_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_sel,
    input  logic  wr_val,
    input  logic  accept,
    input  byte_t wdata,
    output byte_t cur_idx,
    output byte_t cur_byte
);
    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
        byte_t                           idx;
    } store_t;

    store_t st_d, st_q;

    function automatic store_t store_init();
        store_t s;
        s.idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            s.mem[i] = reg_init(byte_t'(i));
        end
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            st_d.idx = wdata;
        end
        if (wr_val && accept) begin
            st_d.mem[st_q.idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= store_init();
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_idx  = st_q.idx;
    assign cur_byte = st_q.mem[st_q.idx];

    // R1
    idx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> st_q.idx == $past(wdata));

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val && !accept) |=> $stable(st_q.mem));

    // R4
    pin_e7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[8'hE7] == 8'hFE);

    // R4
    pin_e8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mem[8'hE8] == 8'hBE);

endmodule

// File: rtl/cfg_window.sv
module cfg_window
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_ADDR  = 16'h03F0,
    parameter int          OFF_W      = 8,
    parameter logic [7:0]  ENABLE_OFF = 8'h85,
    parameter int          ENABLE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [7:0]        host_wdata,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    output logic              io_hit
);
    localparam logic [OFF_W-1:0] EN_OFF = OFF_W'(ENABLE_OFF);
    localparam byte_t            IDLE   = '1;

    typedef struct packed {
        logic  en;
        logic  hit;
        byte_t rdata;
    } top_t;

    top_t  tp_d, tp_q;
    logic  acc, wr_sel, wr_val, rd_any, accept;
    byte_t cur_idx, cur_byte;

    cfgwin_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .open   (tp_q.en),
        .acc    (acc),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .rd_any (rd_any)
    );

    cfgwin_filter u_filter (
        .idx    (cur_idx),
        .val    (io_wdata),
        .accept (accept)
    );

    cfgwin_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wr_val   (wr_val),
        .accept   (accept),
        .wdata    (io_wdata),
        .cur_idx  (cur_idx),
        .cur_byte (cur_byte)
    );

    always_comb begin
        tp_d       = tp_q;
        tp_d.hit   = acc;
        tp_d.rdata = rd_any ? cur_byte : IDLE;
        if (host_wr && host_off == EN_OFF) begin
            tp_d.en = host_wdata[ENABLE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '{en: 1'b0, hit: 1'b0, rdata: IDLE};
        end else begin
            tp_q <= tp_d;
        end
    end

    assign io_hit   = tp_q.hit;
    assign io_rdata = tp_q.rdata;

    // R8
    closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tp_q.en |=> !io_hit);

    // R10
    idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> io_rdata == 8'hFF);

    // R10
    hit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_q.en && (io_wr || io_rd) &&
         (io_addr == ADDR_W'(BASE_ADDR) || io_addr == ADDR_W'(BASE_ADDR + 16'd1)))
        |=> io_hit);

    // R7
    enable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_off == EN_OFF) |=> $stable(tp_q.en));

endmodule

// File: tb/cfg_window_test.sv
module cfg_window_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_off = '0;
    logic [7:0]  host_wdata = '0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_hit;

    typedef struct {
        string      req;
        logic       hit;
        logic [7:0] rdata;
    } exp_t;

    exp_t       sbq[$];
    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_idx;
    logic       ref_en;

    cfg_window uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_off   (host_off),
        .host_wdata (host_wdata),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_rdata   (io_rdata),
        .io_hit     (io_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] init_of(input logic [7:0] i);
        case (i)
            8'hE0: return 8'h3C;
            8'hE2: return 8'h03;
            8'hE3: return 8'hFC;
            8'hE6: return 8'hDE;
            8'hE7: return 8'hFE;
            8'hE8: return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic blocked(input logic [7:0] i);
        return (i <= 8'hDF) || i == 8'hE4 || i == 8'hE5 ||
               (i >= 8'hE9 && i <= 8'hED) || i == 8'hF3 || i == 8'hF5 ||
               i == 8'hF7 || (i >= 8'hF9 && i <= 8'hFB) || i >= 8'hFD;
    endfunction

    function automatic logic takes(input logic [7:0] i, input logic [7:0] v);
        if (i == 8'hE7) return v == 8'hFE;
        if (i == 8'hE8) return v == 8'hBE;
        return !blocked(i);
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual hit/data=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one access per call, expectation queued for the monitor.
    task automatic access(input string req, input logic [15:0] a, input logic w,
                          input logic r, input logic [7:0] d);
        exp_t e;
        logic inwin;
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        host_wr = 1'b0;
        inwin = ref_en && (a == 16'h03F0 || a == 16'h03F1);
        e.req   = req;
        e.hit   = inwin && (w || r);
        e.rdata = (inwin && r) ? ref_mem[ref_idx] : 8'hFF;
        sbq.push_back(e);
        if (inwin && w && a == 16'h03F0) ref_idx = d;
        if (inwin && w && a == 16'h03F1 && takes(ref_idx, d)) ref_mem[ref_idx] = d;
    endtask

    task automatic host(input string req, input logic [7:0] off, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        host_wr = 1'b1; host_off = off; host_wdata = d;
        e.req = req; e.hit = 1'b0; e.rdata = 8'hFF;
        sbq.push_back(e);
        if (off == 8'h85) ref_en = d[1];
    endtask

    task automatic wr_reg(input string req, input logic [7:0] i, input logic [7:0] v);
        access(req, 16'h03F0, 1'b1, 1'b0, i);
        access(req, 16'h03F1, 1'b1, 1'b0, v);
    endtask

    task automatic rd_reg(input string req, input logic [7:0] i);
        access(req, 16'h03F0, 1'b1, 1'b0, i);
        access(req, 16'h03F1, 1'b0, 1'b1, 8'h00);
    endtask

    // Monitor: compares one registered result per accepted access.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.req, {io_hit, io_rdata}, {e.hit, e.rdata});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = init_of(8'(i));
        ref_idx = 8'h00;
        ref_en  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset outputs", {io_hit, io_rdata}, {1'b0, 8'hFF});
        @(negedge clk);
        rst_n = 1'b1;

        // R8: window closed out of reset; writes are dropped.
        wr_reg("R8 closed write", 8'hE0, 8'h11);
        rd_reg("R8 closed read", 8'hE0);
        // R7: other offset with bit 1 set leaves it closed.
        host("R7 other offset", 8'h84, 8'h02);
        rd_reg("R7 still closed", 8'hE0);
        host("R7 open", 8'h85, 8'h02);

        // R6 / R2: reset contents, read at both addresses.
        rd_reg("R6 E0 init", 8'hE0);
        access("R2 read at index port", 16'h03F0, 1'b0, 1'b1, 8'h00);
        rd_reg("R6 E1 zero", 8'hE1);
        rd_reg("R6 E2 init", 8'hE2);
        rd_reg("R6 E3 init", 8'hE3);
        rd_reg("R6 E6 init", 8'hE6);
        rd_reg("R6 E7 init", 8'hE7);
        rd_reg("R6 E8 init", 8'hE8);
        rd_reg("R6 low zero", 8'h00);

        // R5 / R3 / R4 directed writes.
        wr_reg("R5 E0 write", 8'hE0, 8'h5A);
        access("R5 E0 readback", 16'h03F1, 1'b0, 1'b1, 8'h00);
        wr_reg("R3 blocked 10", 8'h10, 8'h77);
        access("R3 10 readback", 16'h03F1, 1'b0, 1'b1, 8'h00);
        wr_reg("R3 blocked E4", 8'hE4, 8'h99);
        access("R3 E4 readback", 16'h03F1, 1'b0, 1'b1, 8'h00);
        wr_reg("R4 E7 wrong", 8'hE7, 8'h12);
        access("R4 E7 readback", 16'h03F1, 1'b0, 1'b1, 8'h00);
        wr_reg("R4 E7 right", 8'hE7, 8'hFE);
        wr_reg("R4 E8 wrong", 8'hE8, 8'h00);
        access("R4 E8 readback", 16'h03F1, 1'b0, 1'b1, 8'h00);

        // R1: index changes the register read.
        access("R1 index F0", 16'h03F0, 1'b1, 1'b0, 8'hF0);
        access("R1 data F0", 16'h03F1, 1'b1, 1'b0, 8'hC3);
        access("R1 index E0", 16'h03F0, 1'b1, 1'b0, 8'hE0);
        access("R1 read E0", 16'h03F1, 1'b0, 1'b1, 8'h00);

        // R9: outside the window.
        access("R9 outside write", 16'h03F2, 1'b1, 1'b0, 8'hEE);
        access("R9 outside read", 16'h03EF, 1'b0, 1'b1, 8'h00);
        access("R9 index kept", 16'h03F1, 1'b0, 1'b1, 8'h00);
        access("R10 idle", 16'h03F1, 1'b0, 1'b0, 8'h00);

        // R8: close, try to change index and data, reopen and verify.
        host("R7 close", 8'h85, 8'hFD);
        access("R8 closed index", 16'h03F0, 1'b1, 1'b0, 8'hF1);
        access("R8 closed data", 16'h03F1, 1'b1, 1'b0, 8'h44);
        host("R7 other offset keeps closed", 8'h86, 8'h02);
        access("R8 still closed", 16'h03F1, 1'b0, 1'b1, 8'h00);
        host("R7 reopen", 8'h85, 8'h02);
        access("R8 state kept", 16'h03F1, 1'b0, 1'b1, 8'h00);

        // R3 / R4 / R5 sweep over every index.
        for (int i = 0; i < 256; i++) begin
            logic [7:0] idx;
            logic [7:0] v;
            string      tag;
            idx = 8'(i);
            v = idx ^ 8'hA5;
            tag = (idx == 8'hE7 || idx == 8'hE8) ? "R4 sweep" :
                  blocked(idx) ? "R3 sweep" : "R5 sweep";
            wr_reg(tag, idx, v);
            access(tag, 16'h03F1, 1'b0, 1'b1, 8'h00);
        end

        access("R10 final idle", 16'h0000, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule